// File: doc/BRIEF.md
# Pointer-Addressed I2C Byte Target

This block is an I2C target that sits in front of a small byte array. It oversamples SCL and SDA with the system clock, finds START, repeated START and STOP, and answers one 7-bit device address fixed by a parameter. An internal address pointer selects the array location. A write transfer loads the pointer from its first byte, and every byte after that is stored at the pointer. A read transfer returns bytes beginning at the pointer.

The pointer moves forward only on an acknowledge clock. It keeps its value across transactions, so a read that follows a STOP directly resumes at the last location left in the pointer. Toward the array the block has a plain synchronous port: an address (the pointer itself), a one-cycle write strobe with write data, and read data that the array returns one clock after the address.

To tolerate a zero data hold time on the bus, the block holds its view of SDA internally for a parameter number of clocks. An SDA edge that shortly follows an SCL fall therefore cannot be taken as a bus condition.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, sda_oe is 0, mem_we is 0 and mem_addr (the pointer) is 0.
- R2: The byte after a START is the device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). On a match the block pulls SDA low during the 9th clock. On a mismatch it never drives SDA and writes nothing until the next START or STOP.
- R3: In a write transfer, the byte after the device address is acknowledged, and its low log2(DEPTH) bits are loaded into the pointer.
- R4: Each later byte of a write transfer is acknowledged and stored at the pointer. The pointer then advances by one on the acknowledge clock, wrapping from DEPTH-1 to 0.
- R5: A repeated START followed by the device address with bit 0 = 1 makes the block send the byte at the pointer, most significant bit first.
- R6: When the controller acknowledges a read byte (SDA low on the 9th clock), the pointer advances by one with wrap, and the next byte comes from the new pointer.
- R7: When the controller does not acknowledge a read byte, the block releases SDA, leaves the pointer unchanged and sends nothing until a START or STOP.
- R8: A read with no word address first (START, device address, bit 0 = 1) starts at the pointer value left by earlier transfers, including the value after reset.
- R9: An SDA change up to HOLD_CYC clocks after SCL falls, or shortly before SCL rises, is never taken as START or STOP. Data bits are sampled on the SCL rising edge.
- R10: SDA is only pulled low or released. The drive changes only while SCL is low, and it is released after a STOP.
- R11: mem_we is a single-cycle pulse issued while SCL is low, with mem_addr equal to the pointer and mem_wdata equal to the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr | output | log2(DEPTH) | Array address, equal to the pointer |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one clock after mem_addr |

## Verification
The hardest case to reach from the ports is an SDA edge that sits right beside an SCL edge. Such an edge comes in the same clock as an SCL fall, or a couple of clocks before an SCL rise, and a naive detector would read it as START or STOP. The stimulus drives data bits at a random offset inside the low phase. Directed writes pin that offset to zero and to the last two clocks before the rise, and the data read back must then be intact. Pointer persistence is reached by chaining sequential reads across the wrap point, ending them with a NACK, and then issuing current-address reads whose first byte reveals the pointer left behind.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WORD,
        ST_WDATA,
        ST_TX,
        ST_RXACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        AK_DEV_WR,
        AK_DEV_RD,
        AK_WORD,
        AK_DATA
    } ack_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_ptr_frontend.sv
module i2c_ptr_frontend
    import i2c_ptr_pkg::*;
#(
    parameter int HOLD_CYC = 60
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_lvl,
    output bus_evt_t evt
);
    logic [1:0] scl_sy, sda_sy;
    logic       scl_s, sda_s, scl_prev;
    logic       scl_d, sda_d, sda_d_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy     <= 2'b11;
            sda_sy     <= 2'b11;
            scl_prev   <= 1'b1;
            sda_d_prev <= 1'b1;
        end else begin
            scl_sy     <= {scl_sy[0], scl_i};
            sda_sy     <= {sda_sy[0], sda_i};
            scl_prev   <= scl_s;
            sda_d_prev <= sda_d;
        end
    end

    assign scl_s = scl_sy[1];
    assign sda_s = sda_sy[1];

    // Delayed copies of both lines, used only for START/STOP detection
    generate
        if (HOLD_CYC > 1) begin : g_line
            logic [HOLD_CYC-1:0] scl_line, sda_line;
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_line <= '1;
                    sda_line <= '1;
                end else begin
                    scl_line <= {scl_line[HOLD_CYC-2:0], scl_s};
                    sda_line <= {sda_line[HOLD_CYC-2:0], sda_s};
                end
            end
            assign scl_d = scl_line[HOLD_CYC-1];
            assign sda_d = sda_line[HOLD_CYC-1];
        end else begin : g_reg
            logic scl_r, sda_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_s;
                    sda_r <= sda_s;
                end
            end
            assign scl_d = scl_r;
            assign sda_d = sda_r;
        end
    endgenerate

    // A bus condition needs SCL high both now and when the SDA edge really happened
    always_comb begin
        evt.start    = sda_d_prev & ~sda_d & scl_s & scl_d;
        evt.stop     = ~sda_d_prev & sda_d & scl_s & scl_d;
        evt.scl_rise = scl_s & ~scl_prev;
        evt.scl_fall = ~scl_s & scl_prev;
        evt.sda      = sda_s;
    end

    assign scl_lvl = scl_s;

endmodule

// File: rtl/i2c_ptr_engine.sv
module i2c_ptr_engine
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         PTR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_oe
);
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    tgt_state_e        state;
    ack_kind_e         kind;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic              acked;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind   <= AK_DEV_WR;
            cnt    <= '0;
            sh     <= '0;
            acked  <= 1'b0;
            ptr    <= '0;
            mem_we <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            state <= ST_ACK;
                            if (state == ST_ADDR) begin
                                if (dev_hit(sh, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    kind   <= sh[0] ? AK_DEV_RD : AK_DEV_WR;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_WORD) begin
                                sda_oe <= 1'b1;
                                kind   <= AK_WORD;
                            end else begin
                                sda_oe <= 1'b1;
                                mem_we <= 1'b1;
                                kind   <= AK_DATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_rise) begin
                            if (kind == AK_WORD)
                                ptr <= sh[PTR_W-1:0];
                            else if (kind == AK_DATA)
                                ptr <= ptr + PTR_ONE;
                        end else if (evt.scl_fall) begin
                            cnt <= '0;
                            if (kind == AK_DEV_RD) begin
                                sh     <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (kind == AK_DEV_WR) ? ST_WORD : ST_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RXACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RXACK: begin
                        if (evt.scl_rise) begin
                            acked <= ~evt.sda;
                            if (!evt.sda)
                                ptr <= ptr + PTR_ONE;
                        end else if (evt.scl_fall) begin
                            if (acked) begin
                                sh     <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                                cnt    <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_wdata = sh;

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         DEPTH    = 64,
    parameter int         HOLD_CYC = 60,
    localparam int        PTR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    bus_evt_t evt;
    logic     scl_lvl;

    i2c_ptr_frontend #(.HOLD_CYC(HOLD_CYC)) u_front (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .evt     (evt)
    );

    i2c_ptr_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .mem_rdata (mem_rdata),
        .ptr       (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe)
    );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_lvl,
    input logic             stop_evt,
    input logic             sda_oe,
    input logic             mem_we,
    input logic [PTR_W-1:0] mem_addr
);
    // R10: the drive to SDA is switched on only while SCL is low
    a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    // R10: the drive is released after a STOP
    a_r10_release_after_stop: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    // R11: the write strobe lasts one cycle
    a_r11_we_one_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R11: writes happen while SCL is low
    a_r11_we_scl_low: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !scl_lvl);

    // R4: the pointer moves only on an SCL-high (acknowledge) clock
    a_r4_ptr_moves_scl_high: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> scl_lvl);

endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .stop_evt (evt.stop),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/i2c_ptr_target_bench.sv
`timescale 1ns/1ps
module i2c_ptr_target_bench;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         HOLD = 8;
    localparam int         HALF = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, mem_we;
    logic [5:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    wire        sda_bus = m_sda & ~sda_oe;

    logic [7:0] mem     [64];
    logic [7:0] exp_mem [64];
    int ref_ptr;
    int vecs = 0, errs = 0;
    int drive_bad = 0, we_bad = 0;
    bit done = 0;
    logic prev_oe = 1'b0, prev_we = 1'b0;

    always #2.5 clk = ~clk;

    i2c_ptr_target #(.DEV_ADDR(DEV), .DEPTH(64), .HOLD_CYC(HOLD)) u_i2c_ptr_target (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Array model with one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // R10 / R11 line monitors
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe != prev_oe && m_scl) drive_bad++;
            if (mem_we && (prev_we || m_scl)) we_bad++;
        end
        prev_oe = sda_oe;
        prev_we = mem_we;
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        cw(10); m_sda = 1'b1; cw(HALF-10);
        m_scl = 1'b1; cw(HALF);
        m_sda = 1'b0; cw(HALF);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        cw(10); m_sda = 1'b0; cw(HALF-10);
        m_scl = 1'b1; cw(HALF);
        m_sda = 1'b1; cw(2*HALF);
    endtask

    task automatic send_bit(input bit b, input int dly);
        cw(dly); m_sda = b; cw(HALF-dly);
        m_scl = 1'b1; cw(HALF);
        m_scl = 1'b0;
    endtask

    task automatic recv_bit(output bit got);
        m_sda = 1'b1; cw(HALF);
        m_scl = 1'b1; cw(HALF/2);
        got = sda_bus; cw(HALF/2);
        m_scl = 1'b0;
    endtask

    // dmode < 0: random SDA change point inside the low phase
    task automatic wr_byte(input logic [7:0] b, input int dmode, output bit ack);
        bit g;
        for (int i = 7; i >= 0; i--)
            send_bit(b[i], (dmode < 0) ? int'($urandom_range(1, HALF-6)) : dmode);
        recv_bit(g);
        ack = ~g;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        bit g;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(g);
            b[i] = g;
        end
        send_bit(~give_ack, 5);
    endtask

    function automatic int inc(input int p);
        return (p + 1) % 64;
    endfunction

    task automatic check_array(input string req);
        int bad = 0;
        for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(req, bad, 0);
    endtask

    task automatic do_write(input int addr, input int n, input int dmode);
        bit ack;
        logic [7:0] d;
        bus_start();
        wr_byte({DEV, 1'b0}, dmode, ack); chk("R2 address ack", ack, 1);
        wr_byte(8'(addr), dmode, ack);    chk("R3 word ack", ack, 1);
        ref_ptr = addr % 64;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            wr_byte(d, dmode, ack); chk("R4 data ack", ack, 1);
            exp_mem[ref_ptr] = d;
            ref_ptr = inc(ref_ptr);
        end
        bus_stop();
        check_array("R4 array contents");
        chk("R4 pointer after write", mem_addr, ref_ptr);
    endtask

    task automatic do_read(input bit with_ptr, input int addr, input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        if (with_ptr) begin
            wr_byte({DEV, 1'b0}, -1, ack); chk("R2 address ack", ack, 1);
            wr_byte(8'(addr), -1, ack);    chk("R3 word ack", ack, 1);
            ref_ptr = addr % 64;
            bus_start();
        end
        wr_byte({DEV, 1'b1}, -1, ack);
        chk(with_ptr ? "R5 read address ack" : "R8 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k < n-1, b);
            if (k == 0) chk(with_ptr ? "R5 first byte" : "R8 first byte", b, exp_mem[ref_ptr]);
            else        chk("R6 sequential byte", b, exp_mem[ref_ptr]);
            if (k < n-1) ref_ptr = inc(ref_ptr);
        end
        chk("R7 NACK released SDA", sda_oe, 0);
        bus_stop();
        chk("R7 pointer after NACK", mem_addr, ref_ptr);
    endtask

    initial begin
        bit ack;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        ref_ptr = 0;
        cw(5);
        chk("R1 sda_oe at reset", sda_oe, 0);
        chk("R1 pointer at reset", mem_addr, 0);
        chk("R1 no write at reset", mem_we, 0);
        rst = 1'b0;
        cw(20);

        // R8: current-address read from the reset pointer
        do_read(1'b0, 0, 2);
        // R4: write across the wrap point
        do_write(62, 4, -1);
        // R6: sequential read across the wrap, R7 NACK keeps pointer
        do_read(1'b1, 62, 4);
        // R8: current-address read resumes at pointer left by the NACK
        do_read(1'b0, 0, 1);

        // R2: mismatched address, following bytes ignored
        bus_start();
        wr_byte({DEV ^ 7'h01, 1'b0}, -1, ack); chk("R2 mismatch no ack", ack, 0);
        wr_byte(8'h05, -1, ack);               chk("R2 mismatch word ignored", ack, 0);
        wr_byte(8'hA5, -1, ack);               chk("R2 mismatch data ignored", ack, 0);
        bus_stop();
        check_array("R2 array untouched");
        chk("R2 pointer untouched", mem_addr, ref_ptr);

        // R9: SDA changes in the same clock as SCL fall, then right before SCL rise
        do_write(20, 3, 0);
        do_read(1'b1, 20, 3);
        do_write(40, 3, HALF-2);
        do_read(1'b1, 40, 3);

        // Random mix
        for (int t = 0; t < 16; t++) begin
            int kind = int'($urandom_range(0, 2));
            int a    = int'($urandom_range(0, 255));
            int n    = int'($urandom_range(1, 4));
            case (kind)
                0: do_write(a, n, -1);
                1: do_read(1'b1, a, n);
                default: do_read(1'b0, 0, n);
            endcase
        end

        chk("R10 drive changed while SCL high", drive_bad, 0);
        chk("R11 write strobe shape", we_bad, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule